// File: doc/BRIEF.md
# Programmable 16-bit Counter-Timer Channel

This block is a single down-counting timer channel. It counts a programmed reload value against a qualified clock and drives one output line. The clock is the block clock gated by a synchronous tick enable. Four waveforms can be selected: a retriggerable one-shot pulse, a rate generator that emits one short pulse per period, a square wave, and a delayed single strobe. In every mode the output rests high and its active level is low.

Software or a neighbouring controller first writes a mode code and then a reload value. In the two periodic modes the load starts the waveform at once, and a low gate holds the waveform in its starting phase. In the two triggered modes the load only arms the channel. A rising gate edge, sampled on tick cycles, starts the sequence. A later rising edge restarts it. The live counter value and the output level are always visible. In square-wave mode the live counter shows the count left in the current half period.

Top module: `ct16_channel`

## Requirements
- R1: After reset the output is high, the count is 0, and the channel is unloaded. Ticks and gate activity change nothing until a reload value is written.
- R2: A mode write takes effect only for the codes 1 (one-shot), 2 (rate), 3 (square) and 5 (strobe). A write with any other code leaves the mode, count and output unchanged, and a running waveform continues.
- R3: One-shot mode: a trigger loads the count with the reload value and drives the output low. The output stays low for exactly the reload value in ticks and then returns high. A retrigger during the pulse restarts the full length.
- R4: Rate mode: the output repeats with a period of the reload value in ticks. It is low for exactly one tick per period. The count runs from the reload value down to 1.
- R5: Square mode with reload N: the output is high for ceil(N/2) ticks and low for floor(N/2) ticks, so an odd N gives a high half one tick longer than the low half. Reload values below 2 are not used in this mode.
- R6: Strobe mode: a trigger loads the count. After the reload value in ticks, the output goes low for exactly one tick and then stays high until the next trigger.
- R7: A reload value of 0 acts as 65536 ticks in every mode.
- R8: A valid mode write drives the output high and holds the counter until a reload value is written. Triggers that arrive before the load are ignored. A trigger is a gate that is high on a tick cycle after being low on the previous tick cycle.
- R9: The count and output change only on cycles with tick enable high, apart from the effect of writes.
- R10: In rate and square modes, a tick with the gate low forces the output high and returns the count to its start value. A reload write restarts the waveform at once from that start value with the output high.
- R11: When a mode write and a reload write occur in the same cycle, only the mode write takes effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Synchronous count enable, one counting clock per high cycle |
| gate | input | 1 | Gate: level in periodic modes, rising edge in triggered modes |
| wr_mode | input | 1 | Mode write strobe |
| mode_in | input | 3 | Mode code: 1, 2, 3 or 5 |
| wr_load | input | 1 | Reload value write strobe |
| load_in | input | 16 | Reload value, 0 meaning 65536 |
| count_o | output | 16 | Current counter value |
| out_o | output | 1 | Channel output, rests high |

## Verification
The hardest case to reach is the full-range reload. One full period of 65536 ticks has to pass with the tick enable held high, and exactly one low tick must appear in it. A directed run near the end covers this case. The other hard cases are retriggers and gate drops that land inside a pulse, and writes that collide with tick cycles. A seeded random phase reaches these by toggling the gate, the tick enable and both write strobes at mixed rates. Short reloads keep many periods in play. A cycle-level reference model in the bench predicts every count and output value.

// File: rtl/ct16_pkg.sv
package ct16_pkg;

  typedef enum logic [2:0] {
    MODE_ONESHOT = 3'd1,
    MODE_RATE    = 3'd2,
    MODE_SQUARE  = 3'd3,
    MODE_STROBE  = 3'd5
  } ct_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARMED = 2'd1,
    ST_RUN   = 2'd2
  } ct_state_e;

  function automatic logic mode_code_ok(input logic [2:0] code);
    return (code == 3'd1) || (code == 3'd2) || (code == 3'd3) || (code == 3'd5);
  endfunction

  function automatic logic mode_periodic(input ct_mode_e m);
    return (m == MODE_RATE) || (m == MODE_SQUARE);
  endfunction

endpackage

// File: rtl/ct16_gate_sense.sv
module ct16_gate_sense (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_en,
  input  logic gate,
  output logic trig_o
);
  logic gate_q;

  // gate is sampled only on counting ticks
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gate_q <= 1'b0;
    end else if (tick_en) begin
      gate_q <= gate;
    end
  end

  assign trig_o = tick_en & gate & ~gate_q;

endmodule

// File: rtl/ct16_half_split.sv
module ct16_half_split #(
  parameter int CNT_W = 16,
  parameter bit UPPER = 1'b1
) (
  input  logic [CNT_W-1:0] reload_i,
  output logic [CNT_W-1:0] half_o
);
  localparam int XW = CNT_W + 2;

  logic [XW-1:0] span;

  // zero stands for the full 2^CNT_W range
  assign span = {1'b0, (reload_i == '0), reload_i};

  generate
    if (UPPER) begin : g_ceil
      assign half_o = CNT_W'((span + XW'(1)) >> 1);
    end else begin : g_floor
      assign half_o = CNT_W'(span >> 1);
    end
  endgenerate

endmodule

// File: rtl/ct16_core.sv
module ct16_core
  import ct16_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  logic             gate,
  input  logic             trig,
  input  logic             wr_mode,
  input  logic [2:0]       mode_in,
  input  logic             wr_load,
  input  logic [CNT_W-1:0] load_in,
  input  logic [CNT_W-1:0] ld_hi,
  input  logic [CNT_W-1:0] rl_hi,
  input  logic [CNT_W-1:0] rl_lo,
  output logic [CNT_W-1:0] reload_o,
  output ct_mode_e         mode_o,
  output logic [CNT_W-1:0] count_o,
  output logic             out_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);
  localparam logic [CNT_W-1:0] TWO = CNT_W'(2);

  ct_mode_e         mode_q,   mode_n;
  ct_state_e        st_q,     st_n;
  logic [CNT_W-1:0] reload_q, reload_n;
  logic [CNT_W-1:0] cnt_q,    cnt_n;
  logic             out_q,    out_n;
  logic [CNT_W-1:0] cnt_dec;
  logic             mode_wr_ok;

  assign cnt_dec    = cnt_q - ONE;
  assign mode_wr_ok = wr_mode && mode_code_ok(mode_in);

  always_comb begin
    mode_n   = mode_q;
    st_n     = st_q;
    reload_n = reload_q;
    cnt_n    = cnt_q;
    out_n    = out_q;
    if (mode_wr_ok) begin
      mode_n = ct_mode_e'(mode_in);
      st_n   = ST_IDLE;
      out_n  = 1'b1;
    end else if (wr_load) begin
      reload_n = load_in;
      if (mode_periodic(mode_q)) begin
        st_n  = ST_RUN;
        out_n = 1'b1;
        cnt_n = (mode_q == MODE_SQUARE) ? ld_hi : load_in;
      end else if (st_q == ST_IDLE) begin
        st_n = ST_ARMED;
      end
    end else if (tick_en) begin
      case (mode_q)
        MODE_RATE: begin
          if (st_q == ST_RUN) begin
            if (!gate) begin
              cnt_n = reload_q;
              out_n = 1'b1;
            end else if (cnt_q == TWO) begin
              cnt_n = ONE;
              out_n = 1'b0;
            end else if (cnt_q == ONE) begin
              cnt_n = reload_q;
              out_n = 1'b1;
            end else begin
              cnt_n = cnt_dec;
            end
          end
        end
        MODE_SQUARE: begin
          if (st_q == ST_RUN) begin
            if (!gate) begin
              cnt_n = rl_hi;
              out_n = 1'b1;
            end else if (cnt_q == ONE) begin
              out_n = ~out_q;
              cnt_n = out_q ? rl_lo : rl_hi;
            end else begin
              cnt_n = cnt_dec;
            end
          end
        end
        MODE_ONESHOT: begin
          if (trig && (st_q != ST_IDLE)) begin
            st_n  = ST_RUN;
            cnt_n = reload_q;
            out_n = 1'b0;
          end else if (st_q == ST_RUN) begin
            cnt_n = cnt_dec;
            if (cnt_q == ONE) begin
              out_n = 1'b1;
              st_n  = ST_ARMED;
            end
          end
        end
        MODE_STROBE: begin
          out_n = 1'b1;
          if (trig && (st_q != ST_IDLE)) begin
            st_n  = ST_RUN;
            cnt_n = reload_q;
          end else if (st_q == ST_RUN) begin
            cnt_n = cnt_dec;
            if (cnt_q == ONE) begin
              out_n = 1'b0;
              st_n  = ST_ARMED;
            end
          end
        end
        default: begin
          out_n = 1'b1;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q   <= MODE_RATE;
      st_q     <= ST_IDLE;
      reload_q <= '0;
      cnt_q    <= '0;
      out_q    <= 1'b1;
    end else begin
      mode_q   <= mode_n;
      st_q     <= st_n;
      reload_q <= reload_n;
      cnt_q    <= cnt_n;
      out_q    <= out_n;
    end
  end

  assign reload_o = reload_q;
  assign mode_o   = mode_q;
  assign count_o  = cnt_q;
  assign out_o    = out_q;

endmodule

// File: rtl/ct16_channel.sv
module ct16_channel
  import ct16_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  logic             gate,
  input  logic             wr_mode,
  input  logic [2:0]       mode_in,
  input  logic             wr_load,
  input  logic [CNT_W-1:0] load_in,
  output logic [CNT_W-1:0] count_o,
  output logic             out_o
);
  logic [1:0]       rst_pipe;
  logic             rst_core_n;
  logic             trig;
  logic [CNT_W-1:0] reload_w;
  logic [CNT_W-1:0] ld_hi, rl_hi, rl_lo;
  ct_mode_e         mode_w;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= 2'b00;
    end else begin
      rst_pipe <= {rst_pipe[0], 1'b1};
    end
  end
  assign rst_core_n = rst_pipe[1];

  ct16_gate_sense u_gate (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .tick_en (tick_en),
    .gate    (gate),
    .trig_o  (trig)
  );

  ct16_half_split #(.CNT_W(CNT_W), .UPPER(1'b1)) u_ld_hi (
    .reload_i (load_in),
    .half_o   (ld_hi)
  );

  ct16_half_split #(.CNT_W(CNT_W), .UPPER(1'b1)) u_rl_hi (
    .reload_i (reload_w),
    .half_o   (rl_hi)
  );

  ct16_half_split #(.CNT_W(CNT_W), .UPPER(1'b0)) u_rl_lo (
    .reload_i (reload_w),
    .half_o   (rl_lo)
  );

  ct16_core #(.CNT_W(CNT_W)) u_core (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .tick_en  (tick_en),
    .gate     (gate),
    .trig     (trig),
    .wr_mode  (wr_mode),
    .mode_in  (mode_in),
    .wr_load  (wr_load),
    .load_in  (load_in),
    .ld_hi    (ld_hi),
    .rl_hi    (rl_hi),
    .rl_lo    (rl_lo),
    .reload_o (reload_w),
    .mode_o   (mode_w),
    .count_o  (count_o),
    .out_o    (out_o)
  );

endmodule

// File: rtl/ct16_channel_chk.sv
module ct16_channel_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick_en,
  input logic             gate,
  input logic             wr_mode,
  input logic [2:0]       mode_in,
  input logic             wr_load,
  input logic [2:0]       mode_w,
  input logic [CNT_W-1:0] count_o,
  input logic             out_o
);
  logic code_ok;
  logic periodic;
  logic quiet;

  assign code_ok  = (mode_in == 3'd1) || (mode_in == 3'd2) || (mode_in == 3'd3) || (mode_in == 3'd5);
  assign periodic = (mode_w == 3'd2) || (mode_w == 3'd3);
  assign quiet    = !wr_mode && !wr_load;

  a_r9_no_tick_no_change: assert property (@(posedge clk) disable iff (!rst_n)
    (quiet && !tick_en) |=> ($stable(count_o) && $stable(out_o)));

  a_r8_mode_write_idles_high: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_mode && code_ok) |=> out_o);

  a_r2_bad_code_keeps_mode: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_mode && !code_ok) |=> $stable(mode_w));

  a_r4_rate_low_one_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_w == 3'd2 && !out_o && tick_en && quiet) |=> out_o);

  a_r6_strobe_one_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_w == 3'd5 && !out_o && tick_en && quiet) |=> out_o);

  a_r10_gate_low_forces_high: assert property (@(posedge clk) disable iff (!rst_n)
    (periodic && tick_en && !gate && quiet) |=> out_o);

  a_r10_load_restarts_high: assert property (@(posedge clk) disable iff (!rst_n)
    (periodic && wr_load && !(wr_mode && code_ok)) |=> out_o);

endmodule

bind ct16_channel ct16_channel_chk #(.CNT_W(CNT_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_core_n),
  .tick_en (tick_en),
  .gate    (gate),
  .wr_mode (wr_mode),
  .mode_in (mode_in),
  .wr_load (wr_load),
  .mode_w  (mode_w),
  .count_o (count_o),
  .out_o   (out_o)
);

// File: tb/ct16_channel_tb_top.sv
module ct16_channel_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        tick_en, gate, wr_mode, wr_load;
  logic [2:0]  mode_in;
  logic [15:0] load_in;
  logic [15:0] count_o;
  logic        out_o;

  int n_chk = 0;
  int n_bad = 0;
  int low_seen = 0;
  bit finished = 0;

  // reference model state
  int m_mode, m_reload, m_st, m_p, m_cnt, m_out, m_gq;

  always #(CLK_PERIOD/2) clk = ~clk;

  ct16_channel dut_i (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .gate(gate),
    .wr_mode(wr_mode), .mode_in(mode_in), .wr_load(wr_load), .load_in(load_in),
    .count_o(count_o), .out_o(out_o)
  );

  function automatic int span(input int r);
    return (r == 0) ? 65536 : r;
  endfunction

  function automatic string mode_tag();
    case (m_mode)
      1: return "R3";
      3: return "R5";
      5: return "R6";
      default: return "R4";
    endcase
  endfunction

  function automatic void periodic_view();
    int n = span(m_reload);
    int h = (n + 1) / 2;
    if (m_mode == 2) begin
      m_cnt = (n - m_p) & 16'hFFFF;
      m_out = (m_p == n - 1) ? 0 : 1;
    end else begin
      m_cnt = ((m_p < h) ? (h - m_p) : (n - m_p)) & 16'hFFFF;
      m_out = (m_p < h) ? 1 : 0;
    end
  endfunction

  function automatic void model_step();
    int  mi = int'(mode_in);
    bit  ok = (mi == 1) || (mi == 2) || (mi == 3) || (mi == 5);
    bit  trg = gate && !m_gq[0];
    if (wr_mode && ok) begin
      m_mode = mi; m_st = 0; m_out = 1;
    end else if (wr_load) begin
      m_reload = int'(load_in);
      if (m_mode == 2 || m_mode == 3) begin
        m_st = 2; m_p = 0; periodic_view();
      end else if (m_st == 0) begin
        m_st = 1;
      end
    end else if (tick_en) begin
      if (m_mode == 2 || m_mode == 3) begin
        if (m_st == 2) begin
          m_p = gate ? (m_p + 1) % span(m_reload) : 0;
          periodic_view();
        end
      end else if (m_mode == 1) begin
        if (trg && m_st != 0) begin
          m_st = 2; m_p = span(m_reload); m_cnt = m_p & 16'hFFFF; m_out = 0;
        end else if (m_st == 2) begin
          m_p--; m_cnt = m_p & 16'hFFFF;
          if (m_p == 0) begin m_out = 1; m_st = 1; end
        end
      end else begin
        m_out = 1;
        if (trg && m_st != 0) begin
          m_st = 2; m_p = span(m_reload); m_cnt = m_p & 16'hFFFF;
        end else if (m_st == 2) begin
          m_p--; m_cnt = m_p & 16'hFFFF;
          if (m_p == 0) begin m_out = 0; m_st = 1; end
        end
      end
    end
    if (tick_en) m_gq = gate ? 1 : 0;
  endfunction

  task automatic check(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic step();
    model_step();
    @(posedge clk);
    #1;
    if (out_o == 1'b0) low_seen++;
    check(mode_tag(), "count", int'(count_o), m_cnt);
    check(mode_tag(), "out", int'(out_o), m_out);
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic do_mode(input int m);
    wr_mode = 1'b1; mode_in = 3'(m);
    step();
    wr_mode = 1'b0;
  endtask

  task automatic do_load(input int v);
    wr_load = 1'b1; load_in = 16'(v);
    step();
    wr_load = 1'b0;
  endtask

  task automatic finish_run();
    finished = 1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      n_bad++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      finish_run();
    end
  end

  initial begin
    int held;
    void'($urandom(32'd24681));
    rst_n = 1'b0; tick_en = 1'b0; gate = 1'b0; wr_mode = 1'b0; wr_load = 1'b0;
    mode_in = 3'd0; load_in = 16'd0;
    m_mode = 2; m_reload = 0; m_st = 0; m_p = 0; m_cnt = 0; m_out = 1; m_gq = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    // R1: reset state
    check("R1", "count after reset", int'(count_o), 0);
    check("R1", "out after reset", int'(out_o), 1);
    tick_en = 1'b1;
    for (int i = 0; i < 6; i++) begin gate = ~gate; step(); end
    check("R1", "unloaded count", int'(count_o), 0);
    check("R1", "unloaded out", int'(out_o), 1);

    // R4: rate, period 5
    gate = 1'b1;
    do_mode(2); do_load(5);
    low_seen = 0; run(10);
    check("R4", "low ticks in two periods", low_seen, 2);

    // R10: gate low holds start value
    gate = 1'b0; run(3);
    check("R10", "count with gate low", int'(count_o), 5);
    check("R10", "out with gate low", int'(out_o), 1);
    gate = 1'b1; run(2);

    // R9: no tick, no change
    held = int'(count_o);
    tick_en = 1'b0; gate = 1'b0; run(4);
    check("R9", "count frozen", int'(count_o), held);
    tick_en = 1'b1; gate = 1'b1;

    // R5: odd square wave
    do_mode(3); do_load(7);
    low_seen = 0; run(14);
    check("R5", "low ticks in two periods", low_seen, 6);

    // R2: unsupported code ignored
    do_mode(4);
    low_seen = 0; run(7);
    check("R2", "square continues after bad code", low_seen, 3);

    // R8: trigger before load ignored
    do_mode(1);
    gate = 1'b0; step(); gate = 1'b1;
    low_seen = 0; run(3);
    check("R8", "no pulse before load", low_seen, 0);

    // R3: one-shot length 4
    gate = 1'b0; do_load(4); step(); gate = 1'b1;
    low_seen = 0; run(10);
    check("R3", "pulse length", low_seen, 4);

    // R6: strobe after 3 ticks
    do_mode(5);
    gate = 1'b0; do_load(3); step(); gate = 1'b1;
    low_seen = 0; run(8);
    check("R6", "strobe count", low_seen, 1);

    // R11: mode write wins over load in the same cycle
    held = int'(count_o);
    wr_mode = 1'b1; mode_in = 3'd2; wr_load = 1'b1; load_in = 16'd9;
    step();
    wr_mode = 1'b0; wr_load = 1'b0;
    low_seen = 0; run(5);
    check("R11", "count held after collided write", int'(count_o), held);
    check("R11", "no waveform after collided write", low_seen, 0);

    // random phase
    for (int i = 0; i < 3000; i++) begin
      tick_en = ($urandom % 4) != 0;
      if (($urandom % 10) == 0) gate = ~gate;
      wr_mode = ($urandom % 50) == 0;
      mode_in = 3'($urandom % 8);
      wr_load = ($urandom % 20) == 0;
      load_in = 16'(2 + $urandom % 11);
      step();
      wr_mode = 1'b0; wr_load = 1'b0;
    end

    // R7: zero reload spans 65536 ticks
    tick_en = 1'b1; gate = 1'b1;
    do_mode(2); do_load(0);
    check("R7", "count after zero load", int'(count_o), 0);
    low_seen = 0; run(65536);
    check("R7", "one low tick per 65536", low_seen, 1);

    finish_run();
  end

endmodule